// File: doc/BRIEF.md
# Embedded Sector Erase Sequencer

This engine carries out a flash erase on a small modelled array. The command controller hands it a mask of sectors (or a whole-chip request) and a one-cycle start strobe. The engine removes every protected sector from the mask. It then walks the remaining sectors in ascending index order. Inside each sector it first drives every cell that is not yet in the programmed state (8'h00) down to 8'h00. Next it applies an erase pulse that lasts a fixed number of clock cycles. It then reads the whole sector back to verify it. If any cell is not 8'hFF, it pulses again, up to a retry limit. When the limit is exhausted, the operation ends with a fail indication.

While the engine runs, a host port gives access to the array. When the engine is idle, the port reads and programs freely. While an erase is running, every read returns a status byte and every host write is dropped. A suspend request is taken at the end of the current erase pulse. While suspended, sectors outside the erase set behave as in idle, and sectors inside it still return the status byte. A resume request continues with the verify of the suspended sector. An active-low asynchronous reset aborts the operation at once.

The array is measured in units of `WORDS_PER_UNIT` bytes. With bottom boot, the sectors hold 2, 1, 1 and 4 units, followed by fifteen sectors of 8 units each: 128 units in 19 sectors. Top boot lists the same sizes in reverse order.

Top module: `erase_seq_engine`

## Requirements
- R1: While reset is low, and after it is released, busy, suspended, done and failFlag are 0. Pulling reset low during an erase drops busy at once, without waiting for a clock edge.
- R2: After a run, every byte of each selected, unprotected sector reads 8'hFF, and sectors that were not selected keep their contents. done is a single-cycle pulse, and busy is 0 while done is 1.
- R3: When chipErase is 1 at start, all 19 sectors are treated as selected, whatever sectorSel holds.
- R4: A sector whose protMask bit is 1 at start is neither preprogrammed nor erased. A host write to a protected sector has no effect.
- R5: Before the first erase pulse, every byte of a selected sector is set to 8'h00. With cellDegraded high, erase pulses change nothing, so the sector reads back all 8'h00.
- R6: If verify still fails after MAX_RETRY pulses on one sector, the run ends with done and failFlag both 1. failFlag clears at the next start.
- R7: A suspend request takes effect only at the end of an erase pulse, never during preprogramming. While suspended, busy stays 1, curSector holds, the state lasts until resume, and sectors outside the erase set can be read and programmed.
- R8: While suspended, a read of a sector inside the erase set returns the status byte 8'hA5.
- R9: After resume, the run finishes and every selected sector reads 8'hFF.
- R10: While an erase runs and is not suspended, every read returns 8'hA5 and host writes change no byte.
- R11: In bottom boot, sector 0 covers units 0-1, sector 1 unit 2, sector 2 unit 3, sector 3 units 4-7, and sector k (k >= 4) units 8(k-3) to 8(k-3)+7.
- R12: A host write in idle stores the old byte ANDed with the write data, so it can only clear bits. Read data appears one clock after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, aborts any operation |
| startPulse | input | 1 | One-cycle start strobe, honoured when idle |
| chipErase | input | 1 | Select every sector at start |
| sectorSel | input | 19 | Sector selection mask, sampled at start |
| protMask | input | 19 | Sector protection mask |
| suspendReq | input | 1 | One-cycle suspend request |
| resumeReq | input | 1 | One-cycle resume request |
| cellDegraded | input | 1 | Cell model: erase pulses have no effect |
| hostAddr | input | ADDR_W | Host byte address |
| hostWe | input | 1 | Host program strobe |
| hostWdata | input | 8 | Host program data |
| busy | output | 1 | Operation in progress, including while suspended |
| suspended | output | 1 | Erase on hold |
| done | output | 1 | One-cycle completion pulse |
| failFlag | output | 1 | Last run failed verify |
| curSector | output | 5 | Index of the sector being processed |
| rdData | output | 8 | Registered read data or status byte |

## Verification
The assertions assume the controller gives start only when busy is low. They also assume that suspend and resume are single-cycle strobes, and that resume is given only while the engine is suspended. The stimulus drives every strobe for exactly one clock and issues resume only after it has seen suspended high. It starts a new run only after it has seen the done pulse of the previous one. Inputs change on the falling edge.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  localparam int SECT_COUNT  = 19;
  localparam int SECT_W      = 5;
  localparam int TOTAL_UNITS = 128;
  localparam logic [7:0] STATUS_BYTE = 8'hA5;
  localparam logic [7:0] CELL_ERASED = 8'hFF;
  localparam logic [7:0] CELL_PROG   = 8'h00;

  typedef enum logic [2:0] {
    S_IDLE, S_SEEK, S_PREP, S_PULSE, S_VERIFY, S_SUSP
  } seq_state_t;

  typedef struct packed {
    logic addrLoad;
    logic addrInc;
    logic progWrite;
    logic erasePulse;
  } dp_strobe_t;

  // Size of a sector in units; top boot mirrors the bottom-boot list.
  function automatic int unsigned unitsOf(int unsigned idx, bit topBoot);
    int unsigned k;
    k = topBoot ? (SECT_COUNT - 1 - idx) : idx;
    case (k)
      0:       return 2;
      1, 2:    return 1;
      3:       return 4;
      default: return 8;
    endcase
  endfunction

  function automatic int unsigned baseOf(int unsigned idx, bit topBoot, int unsigned wpu);
    int unsigned acc;
    acc = 0;
    for (int unsigned j = 0; j < SECT_COUNT; j++)
      if (j < idx) acc += unitsOf(j, topBoot);
    return acc * wpu;
  endfunction

  function automatic int unsigned sectorOf(int unsigned addr, bit topBoot, int unsigned wpu);
    int unsigned hit;
    hit = 0;
    for (int unsigned j = 0; j < SECT_COUNT; j++)
      if (addr >= baseOf(j, topBoot, wpu) &&
          addr <  baseOf(j, topBoot, wpu) + unitsOf(j, topBoot) * wpu)
        hit = j;
    return hit;
  endfunction
endpackage

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_seq_pkg::*;
#(
  parameter int PULSE_CYC = 8,
  parameter int MAX_RETRY = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startPulse,
  input  logic                  chipErase,
  input  logic [SECT_COUNT-1:0] sectorSel,
  input  logic [SECT_COUNT-1:0] protMask,
  input  logic                  suspendReq,
  input  logic                  resumeReq,
  input  logic                  atEnd,
  input  logic                  cellProgrammed,
  input  logic                  cellErased,
  output dp_strobe_t            strobe,
  output logic [SECT_W-1:0]     curSector,
  output logic [SECT_COUNT-1:0] selMask,
  output logic                  busy,
  output logic                  suspended,
  output logic                  done,
  output logic                  failFlag
);
  localparam int TIMER_W = $clog2(PULSE_CYC + 1);
  localparam int RETRY_W = $clog2(MAX_RETRY + 1);

  seq_state_t         state;
  logic [TIMER_W-1:0] pulseTimer;
  logic [RETRY_W-1:0] pulseCount;
  logic               suspPending;
  logic               curSelected;
  logic               pulseLast;

  assign busy        = (state != S_IDLE);
  assign suspended   = (state == S_SUSP);
  assign curSelected = (curSector < SECT_W'(SECT_COUNT)) ? selMask[curSector] : 1'b0;
  assign pulseLast   = (pulseTimer == TIMER_W'(PULSE_CYC - 1));

  always_comb begin
    strobe = '0;
    case (state)
      S_SEEK:   strobe.addrLoad = curSelected;
      S_PREP: begin
        strobe.progWrite = !cellProgrammed;
        strobe.addrInc   = !atEnd;
      end
      S_PULSE: begin
        strobe.erasePulse = pulseLast;
        strobe.addrLoad   = pulseLast;
      end
      S_VERIFY: strobe.addrInc = cellErased && !atEnd;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      curSector   <= '0;
      selMask     <= '0;
      pulseTimer  <= '0;
      pulseCount  <= '0;
      suspPending <= 1'b0;
      done        <= 1'b0;
      failFlag    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (suspendReq && busy && state != S_SUSP) suspPending <= 1'b1;
      case (state)
        S_IDLE: if (startPulse) begin
          selMask     <= (chipErase ? '1 : sectorSel) & ~protMask;
          curSector   <= '0;
          failFlag    <= 1'b0;
          suspPending <= 1'b0;
          state       <= S_SEEK;
        end
        S_SEEK: begin
          if (curSector == SECT_W'(SECT_COUNT)) begin
            done        <= 1'b1;
            suspPending <= 1'b0;
            state       <= S_IDLE;
          end else if (curSelected) begin
            pulseCount <= '0;
            state      <= S_PREP;
          end else begin
            curSector <= curSector + 1'b1;
          end
        end
        S_PREP: if (atEnd) begin
          pulseTimer <= '0;
          state      <= S_PULSE;
        end
        S_PULSE: begin
          if (pulseLast) begin
            pulseCount <= pulseCount + 1'b1;
            if (suspPending) begin
              suspPending <= 1'b0;
              state       <= S_SUSP;
            end else begin
              state <= S_VERIFY;
            end
          end else begin
            pulseTimer <= pulseTimer + 1'b1;
          end
        end
        S_VERIFY: begin
          if (!cellErased) begin
            if (pulseCount == RETRY_W'(MAX_RETRY)) begin
              failFlag    <= 1'b1;
              done        <= 1'b1;
              suspPending <= 1'b0;
              state       <= S_IDLE;
            end else begin
              pulseTimer <= '0;
              state      <= S_PULSE;
            end
          end else if (atEnd) begin
            curSector <= curSector + 1'b1;
            state     <= S_SEEK;
          end
        end
        S_SUSP: if (resumeReq) state <= S_VERIFY;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/erase_seq_dp.sv
module erase_seq_dp
  import erase_seq_pkg::*;
#(
  parameter bit TOP_BOOT       = 1'b0,
  parameter int WORDS_PER_UNIT = 1,
  parameter int ADDR_W         = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dp_strobe_t            strobe,
  input  logic [SECT_W-1:0]     curSector,
  input  logic [SECT_COUNT-1:0] selMask,
  input  logic [SECT_COUNT-1:0] protMask,
  input  logic                  busy,
  input  logic                  suspended,
  input  logic                  cellDegraded,
  input  logic [ADDR_W-1:0]     hostAddr,
  input  logic                  hostWe,
  input  logic [7:0]            hostWdata,
  output logic                  atEnd,
  output logic                  cellProgrammed,
  output logic                  cellErased,
  output logic [7:0]            rdData
);
  localparam int DEPTH = TOTAL_UNITS * WORDS_PER_UNIT;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] walkAddr;
  int unsigned       curBase;
  int unsigned       curLast;
  logic [SECT_W-1:0] hostSect;
  logic              hostOpen;

  assign curBase  = baseOf(32'(curSector), TOP_BOOT, WORDS_PER_UNIT);
  assign curLast  = curBase + unitsOf(32'(curSector), TOP_BOOT) * WORDS_PER_UNIT - 1;
  assign hostSect = SECT_W'(sectorOf(32'(hostAddr), TOP_BOOT, WORDS_PER_UNIT));
  assign hostOpen = !busy || (suspended && !selMask[hostSect]);

  assign atEnd          = (32'(walkAddr) == curLast);
  assign cellProgrammed = (mem[walkAddr] == CELL_PROG);
  assign cellErased     = (mem[walkAddr] == CELL_ERASED);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      walkAddr <= '0;
      rdData   <= '0;
    end else begin
      if (strobe.addrLoad)     walkAddr <= ADDR_W'(curBase);
      else if (strobe.addrInc) walkAddr <= walkAddr + 1'b1;
      rdData <= hostOpen ? mem[hostAddr] : STATUS_BYTE;
    end
  end

  // Array storage is non-volatile in the model: not cleared by reset.
  always_ff @(posedge clk) begin
    if (strobe.erasePulse) begin
      for (int unsigned i = 0; i < DEPTH; i++)
        if (!cellDegraded && i >= curBase && i <= curLast) mem[i] <= CELL_ERASED;
    end else if (strobe.progWrite) begin
      mem[walkAddr] <= CELL_PROG;
    end else if (hostWe && hostOpen && !protMask[hostSect]) begin
      mem[hostAddr] <= mem[hostAddr] & hostWdata;
    end
  end
endmodule

// File: rtl/erase_seq_engine.sv
module erase_seq_engine
  import erase_seq_pkg::*;
#(
  parameter bit TOP_BOOT       = 1'b0,
  parameter int WORDS_PER_UNIT = 1,
  parameter int PULSE_CYC      = 8,
  parameter int MAX_RETRY      = 3,
  localparam int ADDR_W        = $clog2(TOTAL_UNITS * WORDS_PER_UNIT)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startPulse,
  input  logic                  chipErase,
  input  logic [SECT_COUNT-1:0] sectorSel,
  input  logic [SECT_COUNT-1:0] protMask,
  input  logic                  suspendReq,
  input  logic                  resumeReq,
  input  logic                  cellDegraded,
  input  logic [ADDR_W-1:0]     hostAddr,
  input  logic                  hostWe,
  input  logic [7:0]            hostWdata,
  output logic                  busy,
  output logic                  suspended,
  output logic                  done,
  output logic                  failFlag,
  output logic [SECT_W-1:0]     curSector,
  output logic [7:0]            rdData
);
  dp_strobe_t            strobe;
  logic [SECT_COUNT-1:0] selMask;
  logic                  atEnd;
  logic                  cellProgrammed;
  logic                  cellErased;

  erase_seq_ctrl #(.PULSE_CYC(PULSE_CYC), .MAX_RETRY(MAX_RETRY)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .chipErase(chipErase),
    .sectorSel(sectorSel), .protMask(protMask), .suspendReq(suspendReq),
    .resumeReq(resumeReq), .atEnd(atEnd), .cellProgrammed(cellProgrammed),
    .cellErased(cellErased), .strobe(strobe), .curSector(curSector),
    .selMask(selMask), .busy(busy), .suspended(suspended), .done(done),
    .failFlag(failFlag)
  );

  erase_seq_dp #(.TOP_BOOT(TOP_BOOT), .WORDS_PER_UNIT(WORDS_PER_UNIT), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curSector(curSector),
    .selMask(selMask), .protMask(protMask), .busy(busy), .suspended(suspended),
    .cellDegraded(cellDegraded), .hostAddr(hostAddr), .hostWe(hostWe),
    .hostWdata(hostWdata), .atEnd(atEnd), .cellProgrammed(cellProgrammed),
    .cellErased(cellErased), .rdData(rdData)
  );
endmodule

// File: rtl/erase_seq_checker.sv
module erase_seq_checker
  import erase_seq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              suspended,
  input logic              done,
  input logic              failFlag,
  input logic [SECT_W-1:0] curSector,
  input logic [7:0]        rdData
);
  // R2: completion is reported with the engine already idle
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R2: done lasts one cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: fail only rises together with completion
  p_fail_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failFlag) |-> done);

  // R7: a suspended erase still counts as busy
  p_susp_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    suspended |-> busy);

  // R7: sector index holds while suspended
  p_cur_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (suspended && $past(suspended)) |-> $stable(curSector));

  // R10: a running, unsuspended engine hides the array
  p_status_run_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !suspended) |=> (rdData == STATUS_BYTE));
endmodule

bind erase_seq_engine erase_seq_checker u_checker (
  .clk(clk), .rstN(rstN), .busy(busy), .suspended(suspended), .done(done),
  .failFlag(failFlag), .curSector(curSector), .rdData(rdData)
);

// File: tb/erase_seq_engine_bench.sv
`timescale 1ns/1ps
module erase_seq_engine_bench;
  import erase_seq_pkg::*;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  startPulse = 1'b0;
  logic                  chipErase = 1'b0;
  logic [SECT_COUNT-1:0] sectorSel = '0;
  logic [SECT_COUNT-1:0] protMask = '0;
  logic                  suspendReq = 1'b0;
  logic                  resumeReq = 1'b0;
  logic                  cellDegraded = 1'b0;
  logic [6:0]            hostAddr = '0;
  logic                  hostWe = 1'b0;
  logic [7:0]            hostWdata = '0;
  logic                  busy, suspended, done, failFlag;
  logic [SECT_W-1:0]     curSector;
  logic [7:0]            rdData;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  erase_seq_engine u_erase_seq_engine (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .chipErase(chipErase),
    .sectorSel(sectorSel), .protMask(protMask), .suspendReq(suspendReq),
    .resumeReq(resumeReq), .cellDegraded(cellDegraded), .hostAddr(hostAddr),
    .hostWe(hostWe), .hostWdata(hostWdata), .busy(busy), .suspended(suspended),
    .done(done), .failFlag(failFlag), .curSector(curSector), .rdData(rdData)
  );

  task automatic checkEq(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: read data is registered one edge after the address.
  always @(posedge clk) begin
    if (expQ.size() > 0) begin
      logic [7:0] e;
      string t;
      #2;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checkEq(t, 32'(rdData), 32'(e));
    end
  end

  task automatic readExp(int a, logic [7:0] e, string t);
    @(negedge clk);
    hostAddr = 7'(a);
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
  endtask

  task automatic hostProg(int a, logic [7:0] d);
    @(negedge clk);
    hostAddr = 7'(a); hostWdata = d; hostWe = 1'b1;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic startOp(logic chip, logic [SECT_COUNT-1:0] sel);
    @(negedge clk);
    chipErase = chip; sectorSel = sel; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0; chipErase = 1'b0;
  endtask

  task automatic waitDone(string t);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 5000);
    checkEq(t, 32'(done), 32'd1);
    checkEq({t, " busy low with done"}, 32'(busy), 32'd0);
    @(negedge clk);
    checkEq({t, " done single pulse"}, 32'(done), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checkEq("R1 busy in reset", 32'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 busy", 32'(busy), 0);
    checkEq("R1 suspended", 32'(suspended), 0);
    checkEq("R1 done", 32'(done), 0);
    checkEq("R1 fail", 32'(failFlag), 0);

    // R3: whole-chip erase ignores sectorSel
    startOp(1'b1, '0);
    checkEq("R3 busy after start", 32'(busy), 1);
    waitDone("R3 chip erase done");
    checkEq("R3 no fail", 32'(failFlag), 0);
    for (int a = 0; a < 128; a++) readExp(a, 8'hFF, "R3 chip erased");

    // R12: idle programming only clears bits
    hostProg(8, 8'h0F);
    hostProg(8, 8'hF3);
    readExp(8, 8'h03, "R12 and-programming");
    hostProg(0, 8'h55);
    hostProg(2, 8'h66);
    hostProg(16, 8'h77);
    readExp(0, 8'h55, "R12 program addr0");

    // R4: protected sectors 1 and 2 refuse host writes
    protMask = 19'b110;
    hostProg(3, 8'h00);
    readExp(3, 8'hFF, "R4 protected write ignored");

    // R2/R4/R11: sectors 0,1,4 selected, sector 1 protected
    startOp(1'b0, 19'h13);
    readExp(16, STATUS_BYTE, "R10 status while running");
    hostProg(16, 8'h00);
    waitDone("R2 partial erase done");
    readExp(0, 8'hFF, "R2 R11 sector0 low");
    readExp(1, 8'hFF, "R2 R11 sector0 high");
    readExp(2, 8'h66, "R4 R11 protected sector1 kept");
    readExp(3, 8'hFF, "R11 sector2 untouched");
    for (int a = 8; a < 16; a++) readExp(a, 8'hFF, "R2 R11 sector4 erased");
    readExp(16, 8'h77, "R10 R11 sector5 write ignored and unselected");
    readExp(17, 8'hFF, "R2 sector5 unchanged");

    // R7/R8/R9: suspend and resume
    protMask = '0;
    hostProg(8, 8'h11);
    startOp(1'b0, 19'h50);
    suspendReq = 1'b1;
    @(negedge clk);
    suspendReq = 1'b0;
    repeat (8) @(negedge clk);
    checkEq("R7 no suspend during preprogram", 32'(suspended), 0);
    begin
      int n = 0;
      while (!suspended && n < 100) begin
        @(negedge clk);
        n++;
      end
    end
    checkEq("R7 suspended", 32'(suspended), 1);
    checkEq("R7 busy while suspended", 32'(busy), 1);
    checkEq("R7 sector index", 32'(curSector), 4);
    readExp(8, STATUS_BYTE, "R8 selected sector status");
    readExp(24, STATUS_BYTE, "R8 pending sector status");
    readExp(0, 8'hFF, "R7 unselected read");
    hostProg(0, 8'h14);
    readExp(0, 8'h14, "R7 unselected program");
    repeat (30) @(negedge clk);
    checkEq("R7 suspend holds", 32'(suspended), 1);
    checkEq("R7 index holds", 32'(curSector), 4);
    @(negedge clk);
    resumeReq = 1'b1;
    @(negedge clk);
    resumeReq = 1'b0;
    checkEq("R9 resumed", 32'(suspended), 0);
    waitDone("R9 done after resume");
    checkEq("R9 no fail", 32'(failFlag), 0);
    for (int a = 8; a < 16; a++) readExp(a, 8'hFF, "R9 sector4 erased");
    for (int a = 24; a < 32; a++) readExp(a, 8'hFF, "R9 sector6 erased");
    readExp(0, 8'h14, "R7 suspended program kept");

    // R5/R6: degraded cells never erase
    cellDegraded = 1'b1;
    startOp(1'b0, 19'h20);
    waitDone("R6 degraded run done");
    checkEq("R6 fail raised", 32'(failFlag), 1);
    for (int a = 16; a < 24; a++) readExp(a, 8'h00, "R5 preprogrammed");
    cellDegraded = 1'b0;
    startOp(1'b0, 19'h20);
    checkEq("R6 fail cleared at start", 32'(failFlag), 0);
    waitDone("R6 retry run done");
    checkEq("R6 no fail", 32'(failFlag), 0);
    for (int a = 16; a < 24; a++) readExp(a, 8'hFF, "R2 sector5 erased");

    // R1: reset aborts a running erase immediately
    startOp(1'b1, '0);
    repeat (5) @(negedge clk);
    checkEq("R1 busy before abort", 32'(busy), 1);
    rstN = 1'b0;
    #1;
    checkEq("R1 abort drops busy", 32'(busy), 0);
    checkEq("R1 abort suspended", 32'(suspended), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 done after abort", 32'(done), 0);
    checkEq("R1 busy after abort", 32'(busy), 0);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule